// File: doc/BRIEF.md
# D-PHY Lane Timing Counter Calculator

This block turns a PLL high-speed rate in hertz and a set of interface timing values in picoseconds into the counter fields a MIPI D-PHY transmitter lane needs. A single start pulse captures the rate and all seven timing values. The block then works through an ordered list of integer divisions. It first derives the byte-clock period and an escape clock of at most 20 MHz with its own period. It then converts each timing value into a count of the matching clock.

The prepare, zero and trail counts do not depend on the timing values. They come from an internal table banded by PLL rate, and the zero count differs between the clock lane and the data lanes. The wakeup count is fixed. Any count too large for its field is clamped to the field maximum, and a sticky flag records that this happened. The results are meant to be copied into lane registers by surrounding logic once done is high.

Top module: `dphy_lane_timing_calc`

## Requirements
- R1: A start pulse seen while done is high or while the block is idle after reset captures pllRateHz and all seven picosecond inputs. Changing those inputs afterwards, or pulsing start again before done rises, does not change the results of the run in progress.
- R2: done goes low in the cycle after an accepted start. It rises once every output field holds the new run's value, and it stays high with all fields stable until the next start.
- R3: With byteHz = floor(pllRateHz/8) and bytePs = floor(10^12/byteHz), the exit (5 bits), clock-post (4 bits) and clock-pre (4 bits) counts equal ceil(valuePs/bytePs).
- R4: The LPX count (6 bits) is n = ceil(lpxPs/bytePs), less 2 when n is at least 2. An n of 0 or 1 is output unchanged.
- R5: With escDiv = ceil(byteHz/20000000), escHz = floor(byteHz/escDiv) and escPs = floor(10^12/escHz), the turnaround go, sure and wait counts (6 bits each) equal ceil(valuePs/escPs).
- R6: Prepare (7 bits), clock zero (6 bits), data zero (6 bits) and trail (7 bits) come from the first band whose upper limit is at or above the rate. Any rate above 1000 MHz uses the 1000 MHz band. The bands, given as limit: prepare/clock zero/data zero/trail in hex, are: 110:20/16/02/22, 150:06/16/03/45, 200:18/17/04/0B, 250:05/17/05/16, 300:51/18/06/2C, 400:64/19/07/33, 500:20/1B/07/4E, 600:6A/1D/08/3A, 700:3E/1E/08/6A, 800:21/1F/09/29, 1000:09/20/09/27.
- R7: The clock-lane zero count and the data-lane zero count are separate outputs, and the clock-lane value is always the larger one.
- R8: The wakeup count is 0x3FF, given as wakeHi = 2'b11 and wakeLo = 8'hFF.
- R9: A computed count above its field maximum, checked after the LPX adjustment, is output as that maximum and sets overflow. overflow stays set across later runs until reset.
- R10: After reset, done and overflow are 0 and every computed field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation |
| pllRateHz | input | 32 | PLL high-speed rate in Hz |
| exitPs | input | 32 | HS exit time, ps |
| clkPostPs | input | 32 | Clock post time, ps |
| clkPrePs | input | 32 | Clock pre time, ps |
| lpxPs | input | 32 | LPX time, ps |
| taGoPs | input | 32 | Turnaround go time, ps |
| taSurePs | input | 32 | Turnaround sure time, ps |
| taWaitPs | input | 32 | Turnaround wait time, ps |
| lpxCnt | output | 6 | LPX count minus two |
| prepCnt | output | 7 | HS prepare count |
| clkZeroCnt | output | 6 | HS zero count, clock lane |
| dataZeroCnt | output | 6 | HS zero count, data lanes |
| trailCnt | output | 7 | HS trail count |
| exitCnt | output | 5 | HS exit count |
| postCnt | output | 4 | Clock post count |
| preCnt | output | 4 | Clock pre count |
| wakeHi | output | 2 | Wakeup count, upper bits |
| wakeLo | output | 8 | Wakeup count, lower bits |
| taGoCnt | output | 6 | Turnaround go count |
| taSureCnt | output | 6 | Turnaround sure count |
| taWaitCnt | output | 6 | Turnaround wait count |
| done | output | 1 | All fields valid |
| overflow | output | 1 | Sticky saturation flag |

## Verification
The hardest cases to reach are the band edges and the escape divider rounding. A rate exactly on a band limit must stay in that band, while a rate just above it must move to the next. The escape divider must round up whenever the byte clock is not a whole multiple of 20 MHz. The stimulus table therefore puts rates on limits, just above limits and beyond the last limit, and at rates that give several different escape divisors. A second start in mid-run and input changes after start check that the captured values are used. LPX values of 0, 1 and 2 byte periods cover the point where the minus-two adjustment takes effect. A deliberately oversized exit time makes saturation happen, and the sticky flag is then tested across a later clean run.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int LPX_W   = 6;
  localparam int PREP_W  = 7;
  localparam int ZERO_W  = 6;
  localparam int TRAIL_W = 7;
  localparam int EXIT_W  = 5;
  localparam int POST_W  = 4;
  localparam int PRE_W   = 4;
  localparam int TA_W    = 6;

  localparam int NUM_BANDS = 11;

  // Ordered division steps; order matters, later steps use earlier quotients
  typedef enum logic [3:0] {
    S_BYTE_PS, S_ESC_DIV, S_ESC_HZ, S_ESC_PS,
    S_EXIT, S_POST, S_PRE, S_LPX,
    S_TA_GO, S_TA_SURE, S_TA_WAIT
  } stepT;

  typedef struct packed {
    logic capture;
    logic divLoad;
    logic divShift;
    logic store;
    stepT step;
  } ctrlStrobeT;

  typedef struct packed {
    logic [PREP_W-1:0]  prep;
    logic [ZERO_W-1:0]  clkZero;
    logic [ZERO_W-1:0]  dataZero;
    logic [TRAIL_W-1:0] trail;
  } bandRowT;

  localparam int unsigned BAND_MHZ [NUM_BANDS] =
    '{110, 150, 200, 250, 300, 400, 500, 600, 700, 800, 1000};
  localparam logic [PREP_W-1:0] BAND_PREP [NUM_BANDS] =
    '{7'h20, 7'h06, 7'h18, 7'h05, 7'h51, 7'h64, 7'h20, 7'h6A, 7'h3E, 7'h21, 7'h09};
  localparam logic [ZERO_W-1:0] BAND_CZERO [NUM_BANDS] =
    '{6'h16, 6'h16, 6'h17, 6'h17, 6'h18, 6'h19, 6'h1B, 6'h1D, 6'h1E, 6'h1F, 6'h20};
  localparam logic [ZERO_W-1:0] BAND_DZERO [NUM_BANDS] =
    '{6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h07, 6'h08, 6'h08, 6'h09, 6'h09};
  localparam logic [TRAIL_W-1:0] BAND_TRAIL [NUM_BANDS] =
    '{7'h22, 7'h45, 7'h0B, 7'h16, 7'h2C, 7'h33, 7'h4E, 7'h3A, 7'h6A, 7'h29, 7'h27};

  // First band whose limit covers the rate; anything above the top limit uses the top band
  function automatic bandRowT bandLookup(input logic [63:0] rateHz);
    bandRowT row;
    int sel;
    sel = NUM_BANDS - 1;
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (rateHz <= 64'(BAND_MHZ[i]) * 64'd1000000) sel = i;
    end
    row.prep     = BAND_PREP[sel];
    row.clkZero  = BAND_CZERO[sel];
    row.dataZero = BAND_DZERO[sel];
    row.trail    = BAND_TRAIL[sel];
    return row;
  endfunction

endpackage

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
#(
  parameter int DIV_W = 41
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output ctrlStrobeT strobe,
  output logic       done
);

  localparam int   ITER_W    = $clog2(DIV_W);
  localparam stepT LAST_STEP = S_TA_WAIT;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_STORE} stateT;

  stateT             state;
  stepT              step;
  logic [ITER_W-1:0] iter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= S_BYTE_PS;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            done  <= 1'b0;
            step  <= S_BYTE_PS;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          iter  <= '0;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          iter <= iter + ITER_W'(1);
          if (iter == ITER_W'(DIV_W - 1)) state <= ST_STORE;
        end
        ST_STORE: begin
          if (step == LAST_STEP) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            step  <= stepT'(step + 4'd1);
            state <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture  = (state == ST_IDLE) && start;
    strobe.divLoad  = (state == ST_LOAD);
    strobe.divShift = (state == ST_SHIFT);
    strobe.store    = (state == ST_STORE);
    strobe.step     = step;
  end

endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
#(
  parameter int          RATE_W = 32,
  parameter int          PS_W   = 32,
  parameter int          DIV_W  = 41,
  parameter int unsigned ESC_HZ = 20000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic [RATE_W-1:0]  pllRateHz,
  input  logic [PS_W-1:0]    exitPs,
  input  logic [PS_W-1:0]    clkPostPs,
  input  logic [PS_W-1:0]    clkPrePs,
  input  logic [PS_W-1:0]    lpxPs,
  input  logic [PS_W-1:0]    taGoPs,
  input  logic [PS_W-1:0]    taSurePs,
  input  logic [PS_W-1:0]    taWaitPs,
  output logic [LPX_W-1:0]   lpxCnt,
  output logic [PREP_W-1:0]  prepCnt,
  output logic [ZERO_W-1:0]  clkZeroCnt,
  output logic [ZERO_W-1:0]  dataZeroCnt,
  output logic [TRAIL_W-1:0] trailCnt,
  output logic [EXIT_W-1:0]  exitCnt,
  output logic [POST_W-1:0]  postCnt,
  output logic [PRE_W-1:0]   preCnt,
  output logic [TA_W-1:0]    taGoCnt,
  output logic [TA_W-1:0]    taSureCnt,
  output logic [TA_W-1:0]    taWaitCnt,
  output logic               overflow
);

  localparam int NUM_PS = 7;
  localparam logic [DIV_W-1:0] PS_PER_S = DIV_W'(64'd1000000000000);
  localparam logic [DIV_W-1:0] ESC_LIM  = DIV_W'(ESC_HZ);

  function automatic logic [DIV_W-1:0] maxOf(input int w);
    return DIV_W'((64'd1 << w) - 64'd1);
  endfunction

  logic [RATE_W-1:0] rateQ;
  logic [PS_W-1:0]   psQ [NUM_PS];
  logic [DIV_W-1:0]  bytePs, escDiv, escHz, escPs;
  logic [DIV_W-1:0]  quo, dsorQ;
  logic [DIV_W:0]    rem;
  logic [DIV_W-1:0]  byteHz;

  assign byteHz = DIV_W'(rateQ >> 3);

  // Captured picosecond inputs
  logic [PS_W-1:0] psIn [NUM_PS];
  assign psIn[0] = exitPs;
  assign psIn[1] = clkPostPs;
  assign psIn[2] = clkPrePs;
  assign psIn[3] = lpxPs;
  assign psIn[4] = taGoPs;
  assign psIn[5] = taSurePs;
  assign psIn[6] = taWaitPs;

  generate
    for (genvar g = 0; g < NUM_PS; g++) begin : g_cap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                psQ[g] <= '0;
        else if (strobe.capture)  psQ[g] <= psIn[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rateQ <= '0;
    else if (strobe.capture) rateQ <= pllRateHz;
  end

  // Operand selection per step; ceiling done by adding divisor minus one
  logic [DIV_W-1:0] dend, dsor;
  always_comb begin
    dend = '0;
    dsor = '0;
    unique case (strobe.step)
      S_BYTE_PS: begin dend = PS_PER_S;                    dsor = byteHz; end
      S_ESC_DIV: begin dend = byteHz + ESC_LIM - 1'b1;     dsor = ESC_LIM; end
      S_ESC_HZ:  begin dend = byteHz;                      dsor = escDiv; end
      S_ESC_PS:  begin dend = PS_PER_S;                    dsor = escHz; end
      S_EXIT:    begin dend = DIV_W'(psQ[0]) + bytePs - 1'b1; dsor = bytePs; end
      S_POST:    begin dend = DIV_W'(psQ[1]) + bytePs - 1'b1; dsor = bytePs; end
      S_PRE:     begin dend = DIV_W'(psQ[2]) + bytePs - 1'b1; dsor = bytePs; end
      S_LPX:     begin dend = DIV_W'(psQ[3]) + bytePs - 1'b1; dsor = bytePs; end
      S_TA_GO:   begin dend = DIV_W'(psQ[4]) + escPs - 1'b1;  dsor = escPs; end
      S_TA_SURE: begin dend = DIV_W'(psQ[5]) + escPs - 1'b1;  dsor = escPs; end
      S_TA_WAIT: begin dend = DIV_W'(psQ[6]) + escPs - 1'b1;  dsor = escPs; end
      default:   begin dend = '0; dsor = '0; end
    endcase
  end

  // Shared restoring divider, one quotient bit per cycle
  logic [DIV_W:0] remSh;
  assign remSh = {rem[DIV_W-1:0], quo[DIV_W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo   <= '0;
      rem   <= '0;
      dsorQ <= '0;
    end else if (strobe.divLoad) begin
      quo   <= dend;
      rem   <= '0;
      dsorQ <= dsor;
    end else if (strobe.divShift) begin
      if (remSh >= {1'b0, dsorQ}) begin
        rem <= remSh - {1'b0, dsorQ};
        quo <= {quo[DIV_W-2:0], 1'b1};
      end else begin
        rem <= remSh;
        quo <= {quo[DIV_W-2:0], 1'b0};
      end
    end
  end

  // LPX adjustment and clamping to the destination field
  logic [DIV_W-1:0] storeVal, fieldMax, satVal;
  logic             isCount, storeOvf;
  always_comb begin
    storeVal = quo;
    if (strobe.step == S_LPX && quo >= DIV_W'(2)) storeVal = quo - DIV_W'(2);
    isCount = 1'b1;
    unique case (strobe.step)
      S_EXIT:                       fieldMax = maxOf(EXIT_W);
      S_POST:                       fieldMax = maxOf(POST_W);
      S_PRE:                        fieldMax = maxOf(PRE_W);
      S_LPX:                        fieldMax = maxOf(LPX_W);
      S_TA_GO, S_TA_SURE, S_TA_WAIT: fieldMax = maxOf(TA_W);
      default: begin
        fieldMax = '1;
        isCount  = 1'b0;
      end
    endcase
    storeOvf = isCount && (storeVal > fieldMax);
    satVal   = storeOvf ? fieldMax : storeVal;
  end

  bandRowT bandRow;
  assign bandRow = bandLookup(64'(rateQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytePs      <= '0;
      escDiv      <= '0;
      escHz       <= '0;
      escPs       <= '0;
      lpxCnt      <= '0;
      prepCnt     <= '0;
      clkZeroCnt  <= '0;
      dataZeroCnt <= '0;
      trailCnt    <= '0;
      exitCnt     <= '0;
      postCnt     <= '0;
      preCnt      <= '0;
      taGoCnt     <= '0;
      taSureCnt   <= '0;
      taWaitCnt   <= '0;
      overflow    <= 1'b0;
    end else if (strobe.store) begin
      if (storeOvf) overflow <= 1'b1;
      unique case (strobe.step)
        S_BYTE_PS: begin
          bytePs      <= quo;
          prepCnt     <= bandRow.prep;
          clkZeroCnt  <= bandRow.clkZero;
          dataZeroCnt <= bandRow.dataZero;
          trailCnt    <= bandRow.trail;
        end
        S_ESC_DIV: escDiv    <= quo;
        S_ESC_HZ:  escHz     <= quo;
        S_ESC_PS:  escPs     <= quo;
        S_EXIT:    exitCnt   <= satVal[EXIT_W-1:0];
        S_POST:    postCnt   <= satVal[POST_W-1:0];
        S_PRE:     preCnt    <= satVal[PRE_W-1:0];
        S_LPX:     lpxCnt    <= satVal[LPX_W-1:0];
        S_TA_GO:   taGoCnt   <= satVal[TA_W-1:0];
        S_TA_SURE: taSureCnt <= satVal[TA_W-1:0];
        S_TA_WAIT: taWaitCnt <= satVal[TA_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dphy_lane_timing_calc.sv
module dphy_lane_timing_calc
  import dtc_pkg::*;
#(
  parameter int          RATE_W = 32,
  parameter int          PS_W   = 32,
  parameter int          DIV_W  = 41,
  parameter int unsigned ESC_HZ = 20000000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [RATE_W-1:0]  pllRateHz,
  input  logic [PS_W-1:0]    exitPs,
  input  logic [PS_W-1:0]    clkPostPs,
  input  logic [PS_W-1:0]    clkPrePs,
  input  logic [PS_W-1:0]    lpxPs,
  input  logic [PS_W-1:0]    taGoPs,
  input  logic [PS_W-1:0]    taSurePs,
  input  logic [PS_W-1:0]    taWaitPs,
  output logic [LPX_W-1:0]   lpxCnt,
  output logic [PREP_W-1:0]  prepCnt,
  output logic [ZERO_W-1:0]  clkZeroCnt,
  output logic [ZERO_W-1:0]  dataZeroCnt,
  output logic [TRAIL_W-1:0] trailCnt,
  output logic [EXIT_W-1:0]  exitCnt,
  output logic [POST_W-1:0]  postCnt,
  output logic [PRE_W-1:0]   preCnt,
  output logic [1:0]         wakeHi,
  output logic [7:0]         wakeLo,
  output logic [TA_W-1:0]    taGoCnt,
  output logic [TA_W-1:0]    taSureCnt,
  output logic [TA_W-1:0]    taWaitCnt,
  output logic               done,
  output logic               overflow
);

  localparam logic [9:0] WAKE_COUNT = 10'h3FF;

  ctrlStrobeT strobe;

  assign wakeHi = WAKE_COUNT[9:8];
  assign wakeLo = WAKE_COUNT[7:0];

  dtc_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  dtc_datapath #(
    .RATE_W (RATE_W),
    .PS_W   (PS_W),
    .DIV_W  (DIV_W),
    .ESC_HZ (ESC_HZ)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pllRateHz   (pllRateHz),
    .exitPs      (exitPs),
    .clkPostPs   (clkPostPs),
    .clkPrePs    (clkPrePs),
    .lpxPs       (lpxPs),
    .taGoPs      (taGoPs),
    .taSurePs    (taSurePs),
    .taWaitPs    (taWaitPs),
    .lpxCnt      (lpxCnt),
    .prepCnt     (prepCnt),
    .clkZeroCnt  (clkZeroCnt),
    .dataZeroCnt (dataZeroCnt),
    .trailCnt    (trailCnt),
    .exitCnt     (exitCnt),
    .postCnt     (postCnt),
    .preCnt      (preCnt),
    .taGoCnt     (taGoCnt),
    .taSureCnt   (taSureCnt),
    .taWaitCnt   (taWaitCnt),
    .overflow    (overflow)
  );

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
  import dtc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               done,
  input logic               overflow,
  input logic [EXIT_W-1:0]  exitCnt,
  input logic [LPX_W-1:0]   lpxCnt,
  input logic [TA_W-1:0]    taWaitCnt,
  input logic [PREP_W-1:0]  prepCnt,
  input logic [ZERO_W-1:0]  clkZeroCnt,
  input logic [ZERO_W-1:0]  dataZeroCnt
);

  // R2: an accepted start clears done
  a_r2_done_drops: assert property (@(posedge clk) disable iff (!rstN)
    (start && done) |=> !done);

  // R2: results hold while no start arrives
  a_r2_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(exitCnt) && $stable(lpxCnt) && $stable(taWaitCnt)));

  // R9: overflow is sticky
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R7: clock-lane zero exceeds data-lane zero once valid
  a_r7_zero_order: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (clkZeroCnt > dataZeroCnt));

  // R6: a band row is loaded whenever results are valid
  a_r6_prep_loaded: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (prepCnt != '0));

endmodule

bind dphy_lane_timing_calc dtc_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .done        (done),
  .overflow    (overflow),
  .exitCnt     (exitCnt),
  .lpxCnt      (lpxCnt),
  .taWaitCnt   (taWaitCnt),
  .prepCnt     (prepCnt),
  .clkZeroCnt  (clkZeroCnt),
  .dataZeroCnt (dataZeroCnt)
);

// File: tb/test_dphy_lane_timing_calc.sv
module test_dphy_lane_timing_calc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pllRateHz = '0;
  logic [31:0] exitPs = '0, clkPostPs = '0, clkPrePs = '0, lpxPs = '0;
  logic [31:0] taGoPs = '0, taSurePs = '0, taWaitPs = '0;
  logic [5:0]  lpxCnt, clkZeroCnt, dataZeroCnt, taGoCnt, taSureCnt, taWaitCnt;
  logic [6:0]  prepCnt, trailCnt;
  logic [4:0]  exitCnt;
  logic [3:0]  postCnt, preCnt;
  logic [1:0]  wakeHi;
  logic [7:0]  wakeLo;
  logic        done, overflow;

  always #10 clk = ~clk;

  dphy_lane_timing_calc i_dphy_lane_timing_calc (
    .clk(clk), .rstN(rstN), .start(start), .pllRateHz(pllRateHz),
    .exitPs(exitPs), .clkPostPs(clkPostPs), .clkPrePs(clkPrePs), .lpxPs(lpxPs),
    .taGoPs(taGoPs), .taSurePs(taSurePs), .taWaitPs(taWaitPs),
    .lpxCnt(lpxCnt), .prepCnt(prepCnt), .clkZeroCnt(clkZeroCnt),
    .dataZeroCnt(dataZeroCnt), .trailCnt(trailCnt), .exitCnt(exitCnt),
    .postCnt(postCnt), .preCnt(preCnt), .wakeHi(wakeHi), .wakeLo(wakeLo),
    .taGoCnt(taGoCnt), .taSureCnt(taSureCnt), .taWaitCnt(taWaitCnt),
    .done(done), .overflow(overflow)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // rate, expected prepare / clock zero / data zero / trail
  typedef struct packed {
    logic [31:0] rate;
    logic [6:0]  prep;
    logic [5:0]  cz;
    logic [5:0]  dz;
    logic [6:0]  tr;
  } vecT;

  localparam int NUM_VEC = 9;
  localparam vecT VECS [NUM_VEC] = '{
    '{32'd100000000,  7'h20, 6'h16, 6'h02, 7'h22},
    '{32'd110000000,  7'h20, 6'h16, 6'h02, 7'h22},
    '{32'd110000008,  7'h06, 6'h16, 6'h03, 7'h45},
    '{32'd250000000,  7'h05, 6'h17, 6'h05, 7'h16},
    '{32'd300000000,  7'h51, 6'h18, 6'h06, 7'h2C},
    '{32'd480000000,  7'h20, 6'h1B, 6'h07, 7'h4E},
    '{32'd800000000,  7'h21, 6'h1F, 6'h09, 7'h29},
    '{32'd1000000000, 7'h09, 6'h20, 6'h09, 7'h27},
    '{32'd1500000000, 7'h09, 6'h20, 6'h09, 7'h27}
  };

  // Expected values from the requirement formulas
  longint eExit, ePost, ePre, eLpx, eGo, eSure, eWait;
  bit     eOvf = 0;

  function automatic longint cdiv(longint a, longint b);
    return (a + b - 1) / b;
  endfunction

  function automatic longint satW(longint v, int w, inout bit ov);
    longint m;
    m = (longint'(1) << w) - 1;
    if (v > m) begin ov = 1; return m; end
    return v;
  endfunction

  task automatic model(longint rate, longint ex, longint po, longint pr,
                       longint lp, longint go, longint su, longint wa);
    longint byteHz, bytePs, escDiv, escHz, escPs, n;
    byteHz = rate / 8;
    bytePs = 64'd1000000000000 / byteHz;
    escDiv = cdiv(byteHz, 20000000);
    escHz  = byteHz / escDiv;
    escPs  = 64'd1000000000000 / escHz;
    eExit  = satW(cdiv(ex, bytePs), 5, eOvf);
    ePost  = satW(cdiv(po, bytePs), 4, eOvf);
    ePre   = satW(cdiv(pr, bytePs), 4, eOvf);
    n      = cdiv(lp, bytePs);
    if (n >= 2) n = n - 2;
    eLpx   = satW(n, 6, eOvf);
    eGo    = satW(cdiv(go, escPs), 6, eOvf);
    eSure  = satW(cdiv(su, escPs), 6, eOvf);
    eWait  = satW(cdiv(wa, escPs), 6, eOvf);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setInputs(longint rate, longint ex, longint po, longint pr,
                           longint lp, longint go, longint su, longint wa);
    pllRateHz = 32'(rate); exitPs = 32'(ex); clkPostPs = 32'(po); clkPrePs = 32'(pr);
    lpxPs = 32'(lp); taGoPs = 32'(go); taSurePs = 32'(su); taWaitPs = 32'(wa);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone();
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk("R2 done timeout", done, 1);
  endtask

  task automatic checkCounts(string ctx);
    chk({"R3 exit ", ctx}, exitCnt, eExit);
    chk({"R3 post ", ctx}, postCnt, ePost);
    chk({"R3 pre ", ctx}, preCnt, ePre);
    chk({"R4 lpx ", ctx}, lpxCnt, eLpx);
    chk({"R5 go ", ctx}, taGoCnt, eGo);
    chk({"R5 sure ", ctx}, taSureCnt, eSure);
    chk({"R5 wait ", ctx}, taWaitCnt, eWait);
    chk({"R9 overflow ", ctx}, overflow, eOvf);
  endtask

  localparam longint P_EX = 100000, P_PO = 60000, P_PR = 30000, P_LP = 50000;
  localparam longint P_GO = 200000, P_SU = 100000, P_WA = 250000;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done", done, 0);
    chk("R10 overflow", overflow, 0);
    chk("R10 exit", exitCnt, 0);
    chk("R10 prep", prepCnt, 0);
    chk("R10 lpx", lpxCnt, 0);
    chk("R8 wakeHi", wakeHi, 3);
    chk("R8 wakeLo", wakeLo, 255);
    rstN = 1'b1;
    @(negedge clk);

    // Stimulus table: bands, escape divisors (R3 R5 R6 R7)
    for (int v = 0; v < NUM_VEC; v++) begin
      setInputs(VECS[v].rate, P_EX, P_PO, P_PR, P_LP, P_GO, P_SU, P_WA);
      model(VECS[v].rate, P_EX, P_PO, P_PR, P_LP, P_GO, P_SU, P_WA);
      pulseStart();
      if (v == 1) chk("R2 done low after start", done, 0);
      waitDone();
      checkCounts($sformatf("vec%0d", v));
      chk($sformatf("R6 prep vec%0d", v), prepCnt, VECS[v].prep);
      chk($sformatf("R7 clkZero vec%0d", v), clkZeroCnt, VECS[v].cz);
      chk($sformatf("R7 dataZero vec%0d", v), dataZeroCnt, VECS[v].dz);
      chk($sformatf("R6 trail vec%0d", v), trailCnt, VECS[v].tr);
      chk("R8 wake", {wakeHi, wakeLo}, 10'h3FF);
    end

    // R1/R2: inputs change without start; results held
    setInputs(200000000, 900000, 1, 1, 1, 1, 1, 1);
    repeat (60) @(negedge clk);
    chk("R2 done held", done, 1);
    checkCounts("hold");
    chk("R1 prep held", prepCnt, 7'h09);

    // R1: inputs altered and second start issued during a run
    setInputs(800000000, 120000, 40000, 20000, 70000, 150000, 90000, 300000);
    model(800000000, 120000, 40000, 20000, 70000, 150000, 90000, 300000);
    pulseStart();
    setInputs(150000000, 500000, 1, 1, 500000, 1, 1, 1);
    repeat (30) @(negedge clk);
    pulseStart();
    setInputs(100000000, 1, 1, 1, 1, 1, 1, 1);
    waitDone();
    checkCounts("busy");
    chk("R1 prep busy", prepCnt, 7'h21);

    // R4: LPX below, at and just above the minus-two point (bytePs 80000 at 100 MHz)
    for (int k = 0; k < 4; k++) begin
      longint lp;
      lp = (k == 0) ? 0 : (k == 1) ? 1000 : (k == 2) ? 160000 : 160001;
      setInputs(100000000, P_EX, P_PO, P_PR, lp, P_GO, P_SU, P_WA);
      model(100000000, P_EX, P_PO, P_PR, lp, P_GO, P_SU, P_WA);
      pulseStart();
      waitDone();
      chk($sformatf("R4 lpx case%0d", k), lpxCnt, eLpx);
    end

    // R9: oversized exit saturates and sets overflow
    setInputs(800000000, 10000000, P_PO, P_PR, P_LP, P_GO, P_SU, P_WA);
    model(800000000, 10000000, P_PO, P_PR, P_LP, P_GO, P_SU, P_WA);
    pulseStart();
    waitDone();
    chk("R9 exit saturated", exitCnt, 31);
    chk("R9 overflow set", overflow, 1);

    // R9: flag stays through a clean run
    setInputs(300000000, P_EX, P_PO, P_PR, P_LP, P_GO, P_SU, P_WA);
    model(300000000, P_EX, P_PO, P_PR, P_LP, P_GO, P_SU, P_WA);
    pulseStart();
    waitDone();
    checkCounts("sticky");

    // R10: reset clears overflow and done
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 overflow after reset", overflow, 0);
    chk("R10 done after reset", done, 0);
    chk("R10 taWait after reset", taWaitCnt, 0);
    rstN = 1'b1;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule